// File: doc/BRIEF.md
# FM Sound Generator Interval Timers

This block provides the two interval timers of an FM sound generator together with the sample-rate strobe that paces them. A free-running prescaler divides the master clock by a fixed ratio (144 by default) to produce the sample strobe. The fast timer counts sample strobes from a 10-bit load value up to its overflow. The slow timer counts groups of sixteen strobes from an 8-bit load value.

Software drives a small write-only register port. It holds load values, run bits, interrupt-enable bits and flag-clear bits. The fast timer's load value is split across two registers. Its upper eight bits are held in a staging register and only take effect when the lower two bits are written. On overflow each timer reloads its stored value, sets a sticky flag and keeps counting. An interrupt line is raised while an enabled flag is set.

Top module: `fm_timer_top`

## Requirements
- R1: `sample_tick` is high for exactly one clock in every PRESCALE clocks, and it runs freely from reset.
- R2: With load value A, timer A overflows (its flag sets) every PRESCALE×(1024−A) clocks while it runs.
- R3: With load value B, timer B overflows every PRESCALE×16×(256−B) clocks while it runs.
- R4: Register select 0 stages A[9:2] from data[7:0] and does not change the stored value by itself. Select 1 writes A[1:0] from data[1:0] and commits the staged upper bits with them. Select 2 writes B from data[7:0].
- R5: A newly committed load value only takes effect at the next reload or start. The count in progress finishes with its old length.
- R6: Select 3 is control. Data bit 4 clears flag A and bit 5 clears flag B. A flag stays set until its own clear bit is written, and clearing one flag leaves the other unchanged.
- R7: `irq` equals (flag A AND data-bit-2 enable) OR (flag B AND data-bit-3 enable), using the enables last written to control.
- R8: Control bit 0 runs timer A and bit 1 runs timer B. A stopped timer produces no overflow, and stopping a timer leaves its flag unchanged.
- R9: A 0→1 change of a run bit reloads that timer's counter and clears timer B's divide-by-16 stage. With the largest load value, timer A then overflows 1 to PRESCALE clocks after the write, and timer B overflows 15×PRESCALE+1 to 16×PRESCALE clocks after it.
- R10: After reset both flags and `irq` are low and both timers are stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 A high, 1 A low, 2 B, 3 control) |
| wr_data | input | 8 | Write data |
| sample_tick | output | 1 | Sample-rate strobe |
| flag_a | output | 1 | Sticky overflow flag of timer A |
| flag_b | output | 1 | Sticky overflow flag of timer B |
| irq | output | 1 | Interrupt request |

## Verification
A write takes effect at the clock edge on which `wr_en` is sampled. A flag is visible right after the edge on which its overflow strobe lands, and `irq` follows the flags and enables in the same cycle. The bench records the edge index of every write and every flag rise by sampling on the falling clock. Periods are measured as differences between two flag rises, so they are exact. Start latency is checked against a window of PRESCALE edges, because the phase of the free-running strobe at the moment of the write is not fixed.

// File: rtl/fmtmr_pkg.sv
package fmtmr_pkg;
    localparam int TA_W = 10;
    localparam int TB_W = 8;
    localparam int TB_DIV = 16;
    localparam int HI_W = TA_W - 2;

    typedef enum logic [1:0] {
        SEL_A_HI = 2'd0,
        SEL_A_LO = 2'd1,
        SEL_B    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic clr_b;
        logic clr_a;
        logic ie_b;
        logic ie_a;
        logic run_b;
        logic run_a;
    } ctrl_t;

    function automatic logic [TA_W-1:0] join_a(input logic [HI_W-1:0] hi,
                                               input logic [1:0] lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV = 144
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R1
    single_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int W = 10,
    parameter int DIV = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic         start,
    input  logic         run,
    input  logic [W-1:0] load,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = '1;

    logic         adv;
    logic [W-1:0] cnt_q;

    generate
        if (DIV > 1) begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] DLAST = DW'(DIV - 1);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || start)
                    div_q <= '0;
                else if (run && strobe)
                    div_q <= (div_q == DLAST) ? '0 : div_q + 1'b1;
            end
            assign adv = strobe && (div_q == DLAST);
        end else begin : g_nodiv
            assign adv = strobe;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= load;
        else if (run && adv)
            cnt_q <= (cnt_q == TOP) ? load : cnt_q + 1'b1;
    end

    assign ovf = run && adv && !start && (cnt_q == TOP);

    // R8
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(cnt_q));

    // R5
    reload_val_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt_q == $past(load)));

    // R9
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == $past(load)));
endmodule

// File: rtl/fm_timer_top.sv
module fm_timer_top
    import fmtmr_pkg::*;
#(
    parameter int PRESCALE = 144
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic       sample_tick,
    output logic       flag_a,
    output logic       flag_b,
    output logic       irq
);
    logic [HI_W-1:0] a_hi_q;
    logic [TA_W-1:0] a_val_q;
    logic [TB_W-1:0] b_val_q;
    logic run_a_q, run_b_q, ie_a_q, ie_b_q;
    logic fa_q, fb_q;
    logic ovf_a, ovf_b, start_a, start_b;
    logic wr_ctl;
    ctrl_t ctl;

    assign ctl    = ctrl_t'(wr_data[5:0]);
    assign wr_ctl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    assign start_a = wr_ctl && ctl.run_a && !run_a_q;
    assign start_b = wr_ctl && ctl.run_b && !run_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_hi_q  <= '0;
            a_val_q <= '0;
            b_val_q <= '0;
            run_a_q <= 1'b0;
            run_b_q <= 1'b0;
            ie_a_q  <= 1'b0;
            ie_b_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_A_HI: a_hi_q  <= wr_data[HI_W-1:0];
                SEL_A_LO: a_val_q <= join_a(a_hi_q, wr_data[1:0]);
                SEL_B:    b_val_q <= wr_data[TB_W-1:0];
                SEL_CTRL: begin
                    run_a_q <= ctl.run_a;
                    run_b_q <= ctl.run_b;
                    ie_a_q  <= ctl.ie_a;
                    ie_b_q  <= ctl.ie_b;
                end
                default: ;
            endcase
        end
    end

    tmr_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(sample_tick)
    );

    tmr_core #(.W(TA_W), .DIV(1)) u_ta (
        .clk   (clk),
        .rst   (rst),
        .strobe(sample_tick),
        .start (start_a),
        .run   (run_a_q),
        .load  (a_val_q),
        .ovf   (ovf_a)
    );

    tmr_core #(.W(TB_W), .DIV(TB_DIV)) u_tb (
        .clk   (clk),
        .rst   (rst),
        .strobe(sample_tick),
        .start (start_b),
        .run   (run_b_q),
        .load  (b_val_q),
        .ovf   (ovf_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fa_q <= 1'b0;
            fb_q <= 1'b0;
        end else begin
            if (ovf_a)
                fa_q <= 1'b1;
            else if (wr_ctl && ctl.clr_a)
                fa_q <= 1'b0;
            if (ovf_b)
                fb_q <= 1'b1;
            else if (wr_ctl && ctl.clr_b)
                fb_q <= 1'b0;
        end
    end

    assign flag_a = fa_q;
    assign flag_b = fb_q;
    assign irq    = (fa_q && ie_a_q) || (fb_q && ie_b_q);

    // R6
    sticky_a_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_a && !(wr_ctl && ctl.clr_a)) |=> flag_a);

    // R6
    sticky_b_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_b && !(wr_ctl && ctl.clr_b)) |=> flag_b);

    // R4
    staged_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel_e'(wr_sel) == SEL_A_HI) |=> $stable(a_val_q));

    // R8
    stopped_a_chk: assert property (@(posedge clk) disable iff (rst)
        !run_a_q |-> !ovf_a);

    // R7
    quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_a && !flag_b) |-> !irq);
endmodule

// File: tb/sim_fm_timer_top.sv
module sim_fm_timer_top;
    localparam int PRE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic sample_tick, flag_a, flag_b, irq;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ctl = '0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fm_timer_top #(.PRESCALE(PRE)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sample_tick(sample_tick),
        .flag_a(flag_a), .flag_b(flag_b), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d, output int at);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        at = cyc;
    endtask

    task automatic set_ctl(input logic [7:0] v);
        int t;
        ctl = v & 8'h0F;
        wr(2'd3, v, t);
    endtask

    task automatic load_a(input int a);
        int t;
        wr(2'd0, 8'(a >> 2), t);
        wr(2'd1, 8'(a & 3), t);
    endtask

    task automatic wait_flag(input bit which_b, output int t);
        t = -1;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if ((which_b ? flag_b : flag_a) === 1'b1) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic clr(input bit which_b);
        set_ctl(ctl | (which_b ? 8'h20 : 8'h10));
    endtask

    task automatic period(input bit which_b, output int p);
        int t0, t1;
        wait_flag(which_b, t0);
        clr(which_b);
        wait_flag(which_b, t1);
        clr(which_b);
        p = t1 - t0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t, t0, t1, p, last;
        int avals[7] = '{1023, 1022, 1021, 1020, 1008, 1000, 900};
        int bvals[4] = '{255, 254, 253, 250};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 flag_a", flag_a, 0);
        check("R10 flag_b", flag_b, 0);
        check("R10 irq", irq, 0);

        // R1 strobe spacing and width
        last = -1;
        for (int k = 0; k < 6; ) begin
            @(negedge clk);
            if (sample_tick) begin
                if (last >= 0) begin
                    check("R1 spacing", cyc - last, PRE);
                    k++;
                end
                last = cyc;
                @(negedge clk);
                check("R1 width", sample_tick, 0);
            end
        end

        // R2 timer A period sweep
        foreach (avals[i]) begin
            set_ctl(8'h00);
            load_a(avals[i]);
            clr(1'b0);
            set_ctl(8'h01);
            period(1'b0, p);
            check($sformatf("R2 A=%0d", avals[i]), p, PRE * (1024 - avals[i]));
        end

        // R3 timer B period sweep
        set_ctl(8'h00);
        foreach (bvals[i]) begin
            set_ctl(8'h00);
            wr(2'd2, 8'(bvals[i]), t);
            clr(1'b1);
            set_ctl(8'h02);
            period(1'b1, p);
            check($sformatf("R3 B=%0d", bvals[i]), p, PRE * 16 * (256 - bvals[i]));
        end

        // R4 / R5 staged high part, commit mid-count
        set_ctl(8'h00);
        load_a(1020);
        clr(1'b0);
        set_ctl(8'h01);
        wait_flag(1'b0, t0);
        clr(1'b0);
        wr(2'd0, 8'(1016 >> 2), t);
        wait_flag(1'b0, t1);
        check("R4 high part alone", t1 - t0, PRE * 4);
        clr(1'b0);
        wr(2'd1, 8'h00, t);
        t0 = t1;
        wait_flag(1'b0, t1);
        check("R5 count in progress", t1 - t0, PRE * 4);
        clr(1'b0);
        t0 = t1;
        wait_flag(1'b0, t1);
        check("R5 after reload", t1 - t0, PRE * 8);

        // R8 stop keeps flag, no overflow while stopped
        set_ctl(8'h00);
        repeat (100) @(negedge clk);
        check("R8 flag kept", flag_a, 1);
        clr(1'b0);
        repeat (100) @(negedge clk);
        check("R8 no overflow", flag_a, 0);

        // R6 sticky and independent clears
        set_ctl(8'h00);
        load_a(1023);
        wr(2'd2, 8'd255, t);
        clr(1'b1);
        set_ctl(8'h01);
        wait_flag(1'b0, t);
        set_ctl(8'h00);
        repeat (50) @(negedge clk);
        check("R6 sticky", flag_a, 1);
        clr(1'b1);
        @(negedge clk);
        check("R6 clear B leaves A", flag_a, 1);

        // R7 interrupt masking
        check("R7 no enable", irq, 0);
        set_ctl(8'h08);
        @(negedge clk);
        check("R7 wrong enable", irq, 0);
        set_ctl(8'h04);
        @(negedge clk);
        check("R7 enabled", irq, 1);
        clr(1'b0);
        @(negedge clk);
        check("R6 clear A", flag_a, 0);
        check("R7 cleared", irq, 0);
        set_ctl(8'h00);

        // R9 start latency
        for (int r = 0; r < 3; r++) begin
            clr(1'b0);
            repeat (r) @(negedge clk);
            wr(2'd3, 8'h01, t0);
            ctl = 8'h01;
            wait_flag(1'b0, t1);
            check_rng("R9 start A", t1 - t0, 1, PRE);
            set_ctl(8'h00);
        end
        for (int r = 0; r < 3; r++) begin
            clr(1'b1);
            repeat (r) @(negedge clk);
            wr(2'd3, 8'h02, t0);
            ctl = 8'h02;
            wait_flag(1'b1, t1);
            check_rng("R9 start B", t1 - t0, 15 * PRE + 1, 16 * PRE);
            set_ctl(8'h00);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule